// File: doc/BRIEF.md
# Byte-Flagged Two-Way Mailbox Bridge

This block passes short messages between two register ports on a single clock. One is the host port and the other is the local port. Each direction has four 32-bit mailboxes. When one port writes one of its outgoing mailboxes, the same storage becomes the matching incoming mailbox of the other port. Every byte of every mailbox carries a full flag. A byte write sets its flag, and a byte read from the receiving port clears it. Both ports see all flags through their own status register, mirrored to their own point of view.

Each port also has one interrupt output. Each port chooses one byte of one mailbox and can enable either or both of two events on it: the chosen incoming byte turning full, or the chosen outgoing byte turning empty. A detected event latches a sticky pending bit that holds the interrupt high until that port clears it. Reads return data combinationally in the cycle the read strobe is high. Every state change, including the flag clear that a read causes, takes effect at the next clock edge.

Word address map, the same on each port: 0–3 outgoing mailbox 0–3, 4–7 incoming mailbox 0–3, 8 status, 9 control, 10 interrupt configuration, 11 interrupt pending.

Top module: `mbx_bridge`

## Requirements
- R1: A write to address m (0–3) on one port stores the bytes whose byte-enable bit b is 1 into mailbox m and leaves the other bytes unchanged. The stored word reads back at address 4+m on the other port and at address m on the writing port.
- R2: That write sets the full flag of mailbox m byte b, flag index m*4+b, only for the enabled bytes. Flags of bytes that are not enabled keep their value.
- R3: A read at address 4+m clears the flags of the bytes whose byte-enable bit is 1 and leaves the other flags unchanged. The read returns the whole word.
- R4: Reading address 8 returns the status word. Bits 15:0 are the incoming flags of this port and bits 31:16 are its outgoing flags, both at index m*4+b. The incoming half of one port always equals the outgoing half of the other port.
- R5: A write to address 9 with data bit 0 set, from either port, clears every flag of both directions at the next edge and leaves mailbox data intact. With bit 0 clear the write has no effect.
- R6: When a byte is written in the same cycle that it is read or globally cleared, the write wins and the flag ends full.
- R7: Address 10 holds the interrupt configuration: bits 1:0 mailbox select, bits 3:2 byte select, bit 4 incoming-full enable, bit 5 outgoing-empty enable. It reads back as written.
- R8: When incoming-full is enabled and the selected incoming byte flag changes from 0 to 1, pending bit 0 (address 11) sets at that edge and the port's interrupt output goes high.
- R9: When outgoing-empty is enabled and the selected outgoing byte flag changes from 1 to 0, pending bit 1 sets at that edge and the interrupt output goes high.
- R10: Pending bits stay set until the port writes 1 to them at address 11. An event in the same cycle as the clear wins. The interrupt output is high whenever any pending bit of the port is set.
- R11: Each port's configuration, pending bits and interrupt output are independent of the other port's.
- R12: A synchronous active-high reset clears all mailbox data, flags, configuration and pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_addr | input | 4 | Host word address |
| h_be | input | 4 | Host byte enables |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, combinational |
| h_irq | output | 1 | Host interrupt |
| l_wr | input | 1 | Local write strobe |
| l_rd | input | 1 | Local read strobe |
| l_addr | input | 4 | Local word address |
| l_be | input | 4 | Local byte enables |
| l_wdata | input | 32 | Local write data |
| l_rdata | output | 32 | Local read data, combinational |
| l_irq | output | 1 | Local interrupt |

## Verification
The assertions rely on the strobes, addresses, byte enables and write data carrying known values in every cycle after reset. They decode each port's address on their own, so they assume that addresses outside 0–11 never appear together with a strobe. The bench drives every input at each falling edge from a fully defined idle value and only ever issues addresses inside the map. It still makes both ports act in the same cycle, so that the write-versus-read and write-versus-clear conflicts fall within what the properties cover.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int MBX_COUNT = 4;
  localparam int MBX_BYTES = 4;
  localparam int MBX_AW    = 4;

  // position of mailbox m byte b inside a flag vector
  function automatic int flag_pos(input int m, input int b, input int nb);
    return m * nb + b;
  endfunction

  // sticky bit: a set in the same cycle as a clear wins
  function automatic logic sticky_next(input logic q, input logic clr, input logic set);
    return set | (q & ~clr);
  endfunction

  // rising and falling change of one flag between its current and next value
  function automatic logic rose(input logic now_v, input logic next_v);
    return ~now_v & next_v;
  endfunction

  function automatic logic fell(input logic now_v, input logic next_v);
    return now_v & ~next_v;
  endfunction
endpackage

// File: rtl/mbx_chan.sv
module mbx_chan
  import mbx_pkg::*;
#(
  parameter int NMB = MBX_COUNT,
  parameter int NB  = MBX_BYTES,
  localparam int SW = (NMB > 1) ? $clog2(NMB) : 1,
  localparam int DW = NB * 8,
  localparam int NF = NMB * NB
)(
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [SW-1:0]   wr_sel,
  input  logic [NB-1:0]   wr_be,
  input  logic [DW-1:0]   wr_data,
  input  logic            rd_en,
  input  logic [SW-1:0]   rd_sel,
  input  logic [NB-1:0]   rd_be,
  input  logic            clr_all,
  output logic [NF*8-1:0] data_o,
  output logic [NF-1:0]   flags_o,
  output logic [NF-1:0]   flags_nxt_o
);
  logic [NF*8-1:0] data_q;
  logic [NF-1:0]   flg_q;
  logic [NF-1:0]   flg_d;

  for (genvar m = 0; m < NMB; m++) begin : g_mbx
    for (genvar b = 0; b < NB; b++) begin : g_byte
      localparam int I = flag_pos(m, b, NB);
      logic hit_w, hit_r;
      assign hit_w = wr_en && (wr_sel == SW'(m)) && wr_be[b];
      assign hit_r = rd_en && (rd_sel == SW'(m)) && rd_be[b];
      // write dominates read and global clear
      assign flg_d[I] = hit_w ? 1'b1 : ((hit_r || clr_all) ? 1'b0 : flg_q[I]);

      always_ff @(posedge clk) begin
        if (rst) begin
          data_q[I*8 +: 8] <= '0;
          flg_q[I]         <= 1'b0;
        end else begin
          flg_q[I] <= flg_d[I];
          if (hit_w) data_q[I*8 +: 8] <= wr_data[b*8 +: 8];
        end
      end
    end
  end

  assign data_o      = data_q;
  assign flags_o     = flg_q;
  assign flags_nxt_o = flg_d;
endmodule

// File: rtl/mbx_side.sv
module mbx_side
  import mbx_pkg::*;
#(
  parameter int NMB = MBX_COUNT,
  parameter int NB  = MBX_BYTES,
  parameter int AW  = MBX_AW,
  localparam int SW = (NMB > 1) ? $clog2(NMB) : 1,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1,
  localparam int DW = NB * 8,
  localparam int NF = NMB * NB,
  localparam int CW = SW + BW + 2
)(
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [AW-1:0]   bus_addr,
  input  logic [NB-1:0]   bus_be,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            irq,
  output logic [1:0]      pend_o,
  output logic            out_wr,
  output logic [SW-1:0]   out_sel,
  output logic [NB-1:0]   out_be,
  output logic [DW-1:0]   out_wdata,
  output logic            in_rd,
  output logic [SW-1:0]   in_sel,
  output logic [NB-1:0]   in_be,
  output logic            clr_req,
  input  logic [NF*8-1:0] out_data,
  input  logic [NF-1:0]   out_flags,
  input  logic [NF-1:0]   out_flags_nxt,
  input  logic [NF*8-1:0] in_data,
  input  logic [NF-1:0]   in_flags,
  input  logic [NF-1:0]   in_flags_nxt
);
  localparam logic [AW-1:0] A_IN0  = AW'(NMB);
  localparam logic [AW-1:0] A_STAT = AW'(2 * NMB);
  localparam logic [AW-1:0] A_CTRL = AW'(2 * NMB + 1);
  localparam logic [AW-1:0] A_ICFG = AW'(2 * NMB + 2);
  localparam logic [AW-1:0] A_IPND = AW'(2 * NMB + 3);

  logic           is_out, is_in;
  logic [SW-1:0]  sel;
  logic [CW-1:0]  cfg_q;
  logic [1:0]     pend_q, pend_d;
  logic [SW+BW-1:0] sidx;
  logic           fill_ev, empty_ev, w1c_wr;
  logic [DW-1:0]  stat_w;

  assign is_out = bus_addr < A_IN0;
  assign is_in  = !is_out && (bus_addr < A_STAT);
  assign sel    = bus_addr[SW-1:0];

  assign out_wr    = bus_wr && is_out;
  assign out_sel   = sel;
  assign out_be    = bus_be;
  assign out_wdata = bus_wdata;
  assign in_rd     = bus_rd && is_in;
  assign in_sel    = sel;
  assign in_be     = bus_be;
  assign clr_req   = bus_wr && (bus_addr == A_CTRL) && bus_wdata[0];
  assign w1c_wr    = bus_wr && (bus_addr == A_IPND);

  always_comb begin
    stat_w = '0;
    stat_w[NF-1:0]    = in_flags;
    stat_w[2*NF-1:NF] = out_flags;
  end

  always_comb begin
    bus_rdata = '0;
    if (is_out)      bus_rdata = out_data[sel*DW +: DW];
    else if (is_in)  bus_rdata = in_data[sel*DW +: DW];
    else if (bus_addr == A_STAT) bus_rdata = stat_w;
    else if (bus_addr == A_ICFG) bus_rdata = DW'(cfg_q);
    else if (bus_addr == A_IPND) bus_rdata = DW'(pend_q);
  end

  // selected flag index: mailbox select above byte select
  assign sidx     = {cfg_q[SW-1:0], cfg_q[SW+BW-1:SW]};
  assign fill_ev  = cfg_q[SW+BW]     && rose(in_flags[sidx], in_flags_nxt[sidx]);
  assign empty_ev = cfg_q[SW+BW + 1] && fell(out_flags[sidx], out_flags_nxt[sidx]);

  assign pend_d[0] = sticky_next(pend_q[0], w1c_wr && bus_wdata[0], fill_ev);
  assign pend_d[1] = sticky_next(pend_q[1], w1c_wr && bus_wdata[1], empty_ev);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      pend_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (bus_wr && (bus_addr == A_ICFG)) cfg_q <= bus_wdata[CW-1:0];
    end
  end

  assign pend_o = pend_q;
  assign irq    = |pend_q;
endmodule

// File: rtl/mbx_bridge.sv
module mbx_bridge
  import mbx_pkg::*;
#(
  parameter int NMB = MBX_COUNT,
  parameter int NB  = MBX_BYTES,
  parameter int AW  = MBX_AW,
  localparam int SW = (NMB > 1) ? $clog2(NMB) : 1,
  localparam int DW = NB * 8,
  localparam int NF = NMB * NB
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          h_wr,
  input  logic          h_rd,
  input  logic [AW-1:0] h_addr,
  input  logic [NB-1:0] h_be,
  input  logic [DW-1:0] h_wdata,
  output logic [DW-1:0] h_rdata,
  output logic          h_irq,
  input  logic          l_wr,
  input  logic          l_rd,
  input  logic [AW-1:0] l_addr,
  input  logic [NB-1:0] l_be,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  output logic          l_irq
);
  // host-to-local channel
  logic            h_owr, l_ird;
  logic [SW-1:0]   h_osel, l_isel;
  logic [NB-1:0]   h_obe, l_ibe;
  logic [DW-1:0]   h_odata;
  logic [NF*8-1:0] h2l_data;
  logic [NF-1:0]   h2l_flags, h2l_nxt;
  // local-to-host channel
  logic            l_owr, h_ird;
  logic [SW-1:0]   l_osel, h_isel;
  logic [NB-1:0]   l_obe, h_ibe;
  logic [DW-1:0]   l_odata;
  logic [NF*8-1:0] l2h_data;
  logic [NF-1:0]   l2h_flags, l2h_nxt;
  // shared events
  logic            h_clr, l_clr, clr_any;
  logic [1:0]      h_pend, l_pend;

  assign clr_any = h_clr | l_clr;

  mbx_chan #(.NMB(NMB), .NB(NB)) u_h2l (
    .clk(clk), .rst(rst),
    .wr_en(h_owr), .wr_sel(h_osel), .wr_be(h_obe), .wr_data(h_odata),
    .rd_en(l_ird), .rd_sel(l_isel), .rd_be(l_ibe), .clr_all(clr_any),
    .data_o(h2l_data), .flags_o(h2l_flags), .flags_nxt_o(h2l_nxt)
  );

  mbx_chan #(.NMB(NMB), .NB(NB)) u_l2h (
    .clk(clk), .rst(rst),
    .wr_en(l_owr), .wr_sel(l_osel), .wr_be(l_obe), .wr_data(l_odata),
    .rd_en(h_ird), .rd_sel(h_isel), .rd_be(h_ibe), .clr_all(clr_any),
    .data_o(l2h_data), .flags_o(l2h_flags), .flags_nxt_o(l2h_nxt)
  );

  mbx_side #(.NMB(NMB), .NB(NB), .AW(AW)) u_host (
    .clk(clk), .rst(rst),
    .bus_wr(h_wr), .bus_rd(h_rd), .bus_addr(h_addr), .bus_be(h_be),
    .bus_wdata(h_wdata), .bus_rdata(h_rdata), .irq(h_irq), .pend_o(h_pend),
    .out_wr(h_owr), .out_sel(h_osel), .out_be(h_obe), .out_wdata(h_odata),
    .in_rd(h_ird), .in_sel(h_isel), .in_be(h_ibe), .clr_req(h_clr),
    .out_data(h2l_data), .out_flags(h2l_flags), .out_flags_nxt(h2l_nxt),
    .in_data(l2h_data), .in_flags(l2h_flags), .in_flags_nxt(l2h_nxt)
  );

  mbx_side #(.NMB(NMB), .NB(NB), .AW(AW)) u_loc (
    .clk(clk), .rst(rst),
    .bus_wr(l_wr), .bus_rd(l_rd), .bus_addr(l_addr), .bus_be(l_be),
    .bus_wdata(l_wdata), .bus_rdata(l_rdata), .irq(l_irq), .pend_o(l_pend),
    .out_wr(l_owr), .out_sel(l_osel), .out_be(l_obe), .out_wdata(l_odata),
    .in_rd(l_ird), .in_sel(l_isel), .in_be(l_ibe), .clr_req(l_clr),
    .out_data(l2h_data), .out_flags(l2h_flags), .out_flags_nxt(l2h_nxt),
    .in_data(h2l_data), .in_flags(h2l_flags), .in_flags_nxt(h2l_nxt)
  );
endmodule

// File: rtl/mbx_bridge_chk.sv
module mbx_bridge_chk #(
  parameter int NMB = 4,
  parameter int NB  = 4,
  parameter int AW  = 4,
  localparam int DW = NB * 8,
  localparam int NF = NMB * NB
)(
  input logic          clk,
  input logic          rst,
  input logic          h_wr,
  input logic          h_rd,
  input logic [AW-1:0] h_addr,
  input logic [NB-1:0] h_be,
  input logic [DW-1:0] h_wdata,
  input logic          l_wr,
  input logic          l_rd,
  input logic [AW-1:0] l_addr,
  input logic [NB-1:0] l_be,
  input logic [DW-1:0] l_wdata,
  input logic [NF-1:0] h2l_flags,
  input logic [NF-1:0] l2h_flags,
  input logic [1:0]    h_pend,
  input logic [1:0]    l_pend
);
  localparam logic [AW-1:0] MB  = AW'(NMB);
  localparam logic [AW-1:0] CTL = AW'(2 * NMB + 1);
  localparam logic [AW-1:0] PND = AW'(2 * NMB + 3);

  logic [NF-1:0] hw_m, lw_m, hr_m, lr_m;
  logic          clr_c;

  // independent decode of each port into per-flag masks
  always_comb begin
    hw_m = '0; lw_m = '0; hr_m = '0; lr_m = '0;
    for (int m = 0; m < NMB; m++) begin
      for (int b = 0; b < NB; b++) begin
        if (h_wr && h_addr == AW'(m) && h_be[b])      hw_m[m*NB+b] = 1'b1;
        if (l_wr && l_addr == AW'(m) && l_be[b])      lw_m[m*NB+b] = 1'b1;
        if (h_rd && h_addr == AW'(m) + MB && h_be[b]) hr_m[m*NB+b] = 1'b1;
        if (l_rd && l_addr == AW'(m) + MB && l_be[b]) lr_m[m*NB+b] = 1'b1;
      end
    end
  end

  assign clr_c = (h_wr && h_addr == CTL && h_wdata[0]) || (l_wr && l_addr == CTL && l_wdata[0]);

  // R2 and R6: written bytes are full afterwards whatever else happens
  a_r2_write_sets_h2l: assert property (@(posedge clk) disable iff (rst)
    (|hw_m) |=> ((h2l_flags & $past(hw_m)) == $past(hw_m)));
  a_r2_write_sets_l2h: assert property (@(posedge clk) disable iff (rst)
    (|lw_m) |=> ((l2h_flags & $past(lw_m)) == $past(lw_m)));

  // R3: read bytes that are not rewritten end empty
  a_r3_read_clears_h2l: assert property (@(posedge clk) disable iff (rst)
    (|(lr_m & ~hw_m)) |=> ((h2l_flags & $past(lr_m & ~hw_m)) == '0));

  // R3: with no access on a channel its flags hold
  a_r3_idle_holds_l2h: assert property (@(posedge clk) disable iff (rst)
    (lw_m == '0 && hr_m == '0 && !clr_c) |=> $stable(l2h_flags));

  // R5: a global clear leaves only bytes written in that cycle
  a_r5_clear_all: assert property (@(posedge clk) disable iff (rst)
    clr_c |=> ((h2l_flags & ~$past(hw_m)) == '0 && (l2h_flags & ~$past(lw_m)) == '0));

  // R10: pending bits stay set until written with one
  a_r10_host_sticky: assert property (@(posedge clk) disable iff (rst)
    (h_pend[0] && !(h_wr && h_addr == PND && h_wdata[0])) |=> h_pend[0]);
  a_r10_local_sticky: assert property (@(posedge clk) disable iff (rst)
    (l_pend[1] && !(l_wr && l_addr == PND && l_wdata[1])) |=> l_pend[1]);
endmodule

bind mbx_bridge mbx_bridge_chk #(.NMB(NMB), .NB(NB), .AW(AW)) u_chk (
  .clk(clk), .rst(rst),
  .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr), .h_be(h_be), .h_wdata(h_wdata),
  .l_wr(l_wr), .l_rd(l_rd), .l_addr(l_addr), .l_be(l_be), .l_wdata(l_wdata),
  .h2l_flags(h2l_flags), .l2h_flags(l2h_flags), .h_pend(h_pend), .l_pend(l_pend)
);

// File: tb/sim_mbx_bridge.sv
module sim_mbx_bridge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        h_wr = 0, h_rd = 0, l_wr = 0, l_rd = 0;
  logic [3:0]  h_addr = 0, l_addr = 0, h_be = 0, l_be = 0;
  logic [31:0] h_wdata = 0, l_wdata = 0;
  logic [31:0] h_rdata, l_rdata;
  logic        h_irq, l_irq;

  int nchk = 0, nfail = 0;
  bit done = 0;

  // reference model: index 0 = host-to-local, 1 = local-to-host
  logic [15:0] mf [2];
  logic [31:0] md [2][4];
  logic [31:0] cap [2];

  always #10 clk = ~clk;

  mbx_bridge u0 (
    .clk(clk), .rst(rst),
    .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr), .h_be(h_be), .h_wdata(h_wdata),
    .h_rdata(h_rdata), .h_irq(h_irq),
    .l_wr(l_wr), .l_rd(l_rd), .l_addr(l_addr), .l_be(l_be), .l_wdata(l_wdata),
    .l_rdata(l_rdata), .l_irq(l_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  // one clock cycle with both ports driven; read data captured before the edge
  task automatic cyc(input logic hw, input logic hr, input logic [3:0] ha, input logic [3:0] hb,
                     input logic [31:0] hd, input logic lw, input logic lr, input logic [3:0] la,
                     input logic [3:0] lb, input logic [31:0] ld);
    @(negedge clk);
    h_wr = hw; h_rd = hr; h_addr = ha; h_be = hb; h_wdata = hd;
    l_wr = lw; l_rd = lr; l_addr = la; l_be = lb; l_wdata = ld;
    #5;
    cap[0] = h_rdata; cap[1] = l_rdata;
    @(posedge clk); #1;
    h_wr = 0; h_rd = 0; l_wr = 0; l_rd = 0;
  endtask

  task automatic wr(input int s, input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
    if (s == 0) cyc(1, 0, a, be, d, 0, 0, 0, 0, 0);
    else        cyc(0, 0, 0, 0, 0, 1, 0, a, be, d);
  endtask

  task automatic rd(input int s, input logic [3:0] a, input logic [3:0] be);
    if (s == 0) cyc(0, 1, a, be, 0, 0, 0, 0, 0, 0);
    else        cyc(0, 0, 0, 0, 0, 0, 1, a, be, 0);
  endtask

  // model: side s writes its outgoing mailbox m
  function automatic void mw(input int s, input int m, input logic [3:0] be, input logic [31:0] d);
    for (int b = 0; b < 4; b++) if (be[b]) begin
      md[s][m][b*8 +: 8] = d[b*8 +: 8];
      mf[s][m*4+b] = 1'b1;
    end
  endfunction

  // model: side s reads its incoming mailbox m
  function automatic void mr(input int s, input int m, input logic [3:0] be);
    for (int b = 0; b < 4; b++) if (be[b]) mf[1-s][m*4+b] = 1'b0;
  endfunction

  function automatic logic [31:0] stat_exp(input int s);
    return {mf[s], mf[1-s]};
  endfunction

  initial begin
    #(20 * 200000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    mf[0] = 0; mf[1] = 0;
    for (int s = 0; s < 2; s++) for (int m = 0; m < 4; m++) md[s][m] = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;

    // R12: reset state
    rd(0, 8, 4'hF); chk("R12 host status", cap[0], 0);
    rd(1, 10, 4'hF); chk("R12 local config", cap[1], 0);
    rd(1, 4, 4'h0);  chk("R12 local inbox data", cap[1], 0);
    chk("R12 irqs", {h_irq, l_irq}, 0);

    // sweep: both directions, every mailbox, every byte-enable pattern
    for (int s = 0; s < 2; s++)
      for (int m = 0; m < 4; m++)
        for (int be = 0; be < 16; be++) begin
          logic [31:0] d;
          d = (32'h1357_9BDF * (be + 1)) ^ (m << 28) ^ s;
          wr(s, 4'(m), 4'(be), d); mw(s, m, 4'(be), d);
          rd(1 - s, 8, 4'hF); chk("R2 R4 receiver status", cap[1-s], stat_exp(1 - s));
          rd(s, 4'(m), 4'hF); chk("R1 outbox readback", cap[s], md[s][m]);
          rd(1 - s, 4'(4 + m), 4'hF); chk("R1 inbox data", cap[1-s], md[s][m]);
          mr(1 - s, m, 4'hF);
          rd(s, 8, 4'hF); chk("R3 R4 writer status", cap[s], stat_exp(s));
        end

    // R3: partial read clears only the enabled bytes
    wr(0, 2, 4'hF, 32'hA1B2C3D4); mw(0, 2, 4'hF, 32'hA1B2C3D4);
    rd(1, 6, 4'b0101); chk("R3 partial read data", cap[1], 32'hA1B2C3D4); mr(1, 2, 4'b0101);
    rd(1, 8, 4'hF); chk("R3 partial clear", cap[1], stat_exp(1));
    chk("R3 remaining bits", stat_exp(1), 32'h0000_0A00);

    // R6: write and read of the same bytes in one cycle
    cyc(1, 0, 0, 4'b0011, 32'h11223344, 0, 1, 4, 4'hF, 0);
    mr(1, 0, 4'hF); mw(0, 0, 4'b0011, 32'h11223344);
    rd(0, 8, 4'hF); chk("R6 write beats read", cap[0], stat_exp(0));

    // R6: write concurrent with a global clear from the other port
    cyc(1, 0, 1, 4'b0100, 32'h00550000, 1, 0, 9, 4'hF, 1);
    mf[0] = 0; mf[1] = 0; mw(0, 1, 4'b0100, 32'h00550000);
    rd(1, 8, 4'hF); chk("R6 write beats clear", cap[1], stat_exp(1));

    // R5: global clear from each port, data preserved, bit0 clear ignored
    wr(0, 3, 4'hF, 32'hCAFEF00D); mw(0, 3, 4'hF, 32'hCAFEF00D);
    wr(1, 0, 4'hF, 32'h0BADBEEF); mw(1, 0, 4'hF, 32'h0BADBEEF);
    wr(1, 9, 4'hF, 32'hFFFF_FFFE);
    rd(0, 8, 4'hF); chk("R5 bit0 clear ignored", cap[0], stat_exp(0));
    wr(0, 9, 4'hF, 1); mf[0] = 0; mf[1] = 0;
    rd(1, 8, 4'hF); chk("R5 host clear", cap[1], 0);
    rd(1, 7, 4'h0); chk("R5 data kept", cap[1], 32'hCAFEF00D);
    wr(0, 2, 4'hF, 32'h5); mw(0, 2, 4'hF, 32'h5);
    wr(1, 9, 4'hF, 1); mf[0] = 0; mf[1] = 0;
    rd(0, 8, 4'hF); chk("R5 local clear", cap[0], 0);

    // R7, R8: host incoming-full on mailbox 2 byte 1
    wr(0, 10, 4'hF, 32'h16);
    rd(0, 10, 4'hF); chk("R7 config readback", cap[0], 32'h16);
    wr(1, 2, 4'b0001, 32'h1); mw(1, 2, 4'b0001, 32'h1);
    chk("R8 other byte no irq", h_irq, 0);
    wr(1, 2, 4'b0010, 32'h200); mw(1, 2, 4'b0010, 32'h200);
    chk("R8 host irq", h_irq, 1);
    chk("R11 local irq quiet", l_irq, 0);
    rd(0, 11, 4'hF); chk("R8 pending bit0", cap[0], 1);
    // R10: sticky across the read that empties the byte
    rd(0, 6, 4'hF); mr(0, 2, 4'hF);
    chk("R10 sticky", h_irq, 1);
    wr(0, 11, 4'hF, 1); chk("R10 cleared", h_irq, 0);
    // R10: event in the clearing cycle wins
    cyc(1, 0, 11, 4'hF, 1, 1, 0, 2, 4'b0010, 32'h300);
    mw(1, 2, 4'b0010, 32'h300);
    chk("R10 set beats clear", h_irq, 1);
    wr(0, 11, 4'hF, 1); chk("R10 cleared again", h_irq, 0);

    // R9, R11: local outgoing-empty on mailbox 1 byte 3
    wr(1, 10, 4'hF, 32'h2D);
    rd(1, 10, 4'hF); chk("R7 local config", cap[1], 32'h2D);
    rd(0, 10, 4'hF); chk("R11 host config kept", cap[0], 32'h16);
    wr(1, 1, 4'b1000, 32'h7700_0000); mw(1, 1, 4'b1000, 32'h7700_0000);
    chk("R9 fill does not fire", l_irq, 0);
    rd(0, 5, 4'b1000); mr(0, 1, 4'b1000);
    chk("R9 local irq", l_irq, 1);
    chk("R11 host irq quiet", h_irq, 0);
    rd(1, 11, 4'hF); chk("R9 pending bit1", cap[1], 2);
    wr(1, 11, 4'hF, 1); chk("R10 wrong bit keeps", l_irq, 1);
    wr(1, 11, 4'hF, 2); chk("R10 local cleared", l_irq, 0);

    rd(0, 8, 4'hF); chk("R4 final host status", cap[0], stat_exp(0));
    rd(1, 8, 4'hF); chk("R4 final local status", cap[1], stat_exp(1));

    finish_run();
  end
endmodule